// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of a serial channel. It shifts bytes out on one line, either as asynchronous character frames or as a bare 8-bit synchronous stream. The host presents a byte together with a one-cycle write strobe. A single bit-rate tick input decides when the line moves on to the next bit. The clock that produces that tick is supplied from outside the block.

Behind the shift register sits a one-byte holding buffer. While it is active, the host can queue the next byte during a frame. When the current frame's last bit ends, the held byte moves into the shifter on the same tick, so no idle gap appears between frames. Two status flags report the state: `busy` is high while a frame is on the line, and `buf_empty` is low while a byte is waiting in the holding buffer. The buffer is optional in the two main modes and always on in the two auxiliary modes. A synchronous clear input abandons the current frame and any queued byte.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After `rst_n` goes low, and one cycle after `srst` is sampled high, `txd` is 1, `busy` is 0 and `buf_empty` is 1. Any frame in progress and any held byte are discarded, so later ticks start nothing.
- R2: With `mode`=2'b01 (character mode), a frame is a 0 start bit, then the 8 data bits least significant first whatever `msb_first` holds, then stop bits at 1. Whenever `busy` is 0, `txd` is 1.
- R3: In character mode, `two_stop`=1 gives two stop-bit periods and `two_stop`=0 gives one. A frame therefore spans 11 or 10 ticks.
- R4: With `mode`=2'b00 (shifter mode) and with `mode`=2'b10 or 2'b11 (auxiliary modes), a frame is the 8 data bits with no start or stop bits. `msb_first`=1 sends bit 7 first and `msb_first`=0 sends bit 0 first. `two_stop` is ignored.
- R5: Each bit stays on `txd` until a cycle with `bit_tick` high. Each tick moves the line on by one bit. The tick in the last bit period ends the frame.
- R6: A write while `busy` is 0 loads the shift register directly. In the next cycle `busy` is 1, `buf_empty` is 1 and `txd` shows the first bit of the frame.
- R7: The buffer is active when `dbuf_en`=1 in modes 2'b00 and 2'b01, and always in modes 2'b10 and 2'b11. With the buffer active, a write during a frame stores the byte and drives `buf_empty` to 0 in the next cycle. A further write before that byte is taken replaces it.
- R8: When a frame ends and a byte is held, that byte moves to the shifter on the same tick. `busy` stays 1, `buf_empty` returns to 1, and the next frame's first bit follows at once.
- R9: With `dbuf_en`=0 in modes 2'b00 and 2'b01, a write during a frame is dropped. `buf_empty` stays 1, and the frame ends with `busy` falling to 0.
- R10: While `busy` is 0, `buf_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous clear of frame and buffer |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| wr_data | input | 8 | Byte to send |
| mode | input | 2 | 00 shifter, 01 character, 10/11 auxiliary |
| dbuf_en | input | 1 | Holding buffer enable for modes 00 and 01 |
| msb_first | input | 1 | Bit order in non-character modes |
| two_stop | input | 1 | Two stop bits in character mode |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial data line, idles high |
| busy | output | 1 | Frame in progress |
| buf_empty | output | 1 | Holding buffer holds no byte |

## Verification
The bound checker watches the cycle-level rules on every cycle:
- an idle line is high and an idle transmitter reports an empty buffer;
- a bit stays put until a tick arrives;
- a clear returns the block to idle;
- a write during a frame either fills the buffer or is dropped, depending on whether buffering is active;
- an idle-time write starts a frame with a low start bit in character mode.

Only the bench's scenarios can show the actual bit sequence of each frame, its length under each stop setting and bit order, and the gapless hand-over of a held byte. The same holds for replacement of a held byte by a later write and for the loss of a queued byte after a clear.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    typedef enum logic [1:0] {
        MODE_SHIFT = 2'b00,
        MODE_CHAR  = 2'b01,
        MODE_AUX0  = 2'b10,
        MODE_AUX1  = 2'b11
    } tx_mode_e;

    // Auxiliary modes force the holding buffer on.
    function automatic logic buf_forced(input tx_mode_e m);
        return (m == MODE_AUX0) || (m == MODE_AUX1);
    endfunction

endpackage

// File: rtl/ser_tx_framer.sv
module ser_tx_framer
    import ser_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + 3,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  tx_mode_e           mode,
    input  logic               msb_first,
    input  logic               two_stop,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   len
);
    localparam logic [CNT_W-1:0] LEN_RAW  = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LEN_CH1  = CNT_W'(DATA_W + 2);
    localparam logic [CNT_W-1:0] LEN_CH2  = CNT_W'(DATA_W + 3);

    logic [DATA_W-1:0] reversed;
    logic [DATA_W-1:0] ordered;
    logic              use_msb;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rev
        assign reversed[gi] = data[DATA_W-1-gi];
    end

    always_comb begin
        use_msb = msb_first && (mode != MODE_CHAR);
        ordered = use_msb ? reversed : data;
        if (mode == MODE_CHAR) begin
            frame = {2'b11, ordered, 1'b0};
            len   = two_stop ? LEN_CH2 : LEN_CH1;
        end else begin
            frame = {3'b111, ordered};
            len   = LEN_RAW;
        end
    end

endmodule

// File: rtl/ser_tx_holdbuf.sv
module ser_tx_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              put,
    input  logic [DATA_W-1:0] put_data,
    input  logic              take,
    output logic [DATA_W-1:0] held_data,
    output logic              held_full
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (srst) begin
            hold_d.full = 1'b0;
        end else if (put) begin
            hold_d.data = put_data;
            hold_d.full = 1'b1;
        end else if (take) begin
            hold_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign held_data = hold_q.data;
    assign held_full = hold_q.full;

endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter #(
    parameter int FRAME_W = 11,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               srst,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_frame,
    input  logic [CNT_W-1:0]   load_len,
    input  logic               tick,
    output logic               txd,
    output logic               busy,
    output logic               last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [CNT_W-1:0]   left;
        logic               busy;
    } shift_t;

    shift_t sh_d, sh_q;
    logic   at_last;

    assign at_last = sh_q.busy && (sh_q.left == ONE);

    always_comb begin
        sh_d = sh_q;
        if (srst) begin
            sh_d.frame = '1;
            sh_d.left  = '0;
            sh_d.busy  = 1'b0;
        end else if (load) begin
            sh_d.frame = load_frame;
            sh_d.left  = load_len;
            sh_d.busy  = 1'b1;
        end else if (sh_q.busy && tick) begin
            if (at_last) begin
                sh_d.frame = '1;
                sh_d.left  = '0;
                sh_d.busy  = 1'b0;
            end else begin
                sh_d.frame = {1'b1, sh_q.frame[FRAME_W-1:1]};
                sh_d.left  = sh_q.left - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.frame <= '1;
            sh_q.left  <= '0;
            sh_q.busy  <= 1'b0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign txd  = sh_q.frame[0];
    assign busy = sh_q.busy;
    assign last = at_last;

endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf
    import ser_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        mode,
    input  logic              dbuf_en,
    input  logic              msb_first,
    input  logic              two_stop,
    input  logic              bit_tick,
    output logic              txd,
    output logic              busy,
    output logic              buf_empty
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    tx_mode_e           mode_e;
    logic               buf_on;
    logic               sh_busy, sh_last, sh_free;
    logic               held_full;
    logic [DATA_W-1:0]  held_data;
    logic               do_load, do_take, do_put;
    logic [DATA_W-1:0]  load_data;
    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   len;

    always_comb begin
        mode_e    = tx_mode_e'(mode);
        buf_on    = dbuf_en || buf_forced(mode_e);
        sh_free   = !sh_busy || (bit_tick && sh_last);
        do_take   = sh_free && held_full;
        do_load   = !srst && sh_free && (held_full || wr_en);
        load_data = held_full ? held_data : wr_data;
        // A write goes to the buffer unless it can go straight to a free shifter.
        do_put    = wr_en && buf_on && (!sh_free || held_full);
    end

    ser_tx_framer #(
        .DATA_W (DATA_W),
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) i_framer (
        .data     (load_data),
        .mode     (mode_e),
        .msb_first(msb_first),
        .two_stop (two_stop),
        .frame    (frame),
        .len      (len)
    );

    ser_tx_holdbuf #(
        .DATA_W(DATA_W)
    ) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .put      (do_put),
        .put_data (wr_data),
        .take     (do_take),
        .held_data(held_data),
        .held_full(held_full)
    );

    ser_tx_shifter #(
        .FRAME_W(FRAME_W),
        .CNT_W  (CNT_W)
    ) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (srst),
        .load      (do_load),
        .load_frame(frame),
        .load_len  (len),
        .tick      (bit_tick),
        .txd       (txd),
        .busy      (sh_busy),
        .last      (sh_last)
    );

    assign busy      = sh_busy;
    assign buf_empty = !held_full;

endmodule

// File: rtl/ser_tx_dbuf_chk.sv
module ser_tx_dbuf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       srst,
    input logic       wr_en,
    input logic [1:0] mode,
    input logic       dbuf_en,
    input logic       bit_tick,
    input logic       txd,
    input logic       busy,
    input logic       buf_empty
);
    logic buf_active;
    assign buf_active = dbuf_en || mode[1];

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> buf_empty); // R10

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd); // R2

    AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bit_tick && !srst |=> busy && $stable(txd)); // R5

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !busy && buf_empty && txd); // R1

    AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !busy && !srst |=> busy && buf_empty); // R6

    AST_QUEUE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && busy && !bit_tick && !srst && buf_active |=> !buf_empty); // R7

    AST_NOBUF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && busy && !srst && !buf_active && buf_empty |=> buf_empty); // R9

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && ($past(mode) == 2'b01) |-> !txd); // R2

endmodule

bind ser_tx_dbuf ser_tx_dbuf_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst     (srst),
    .wr_en    (wr_en),
    .mode     (mode),
    .dbuf_en  (dbuf_en),
    .bit_tick (bit_tick),
    .txd      (txd),
    .busy     (busy),
    .buf_empty(buf_empty)
);

// File: tb/test_ser_tx_dbuf.sv
module test_ser_tx_dbuf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       srst = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] mode = 2'b01;
    logic       dbuf_en = 1'b1;
    logic       msb_first = 1'b0;
    logic       two_stop = 1'b0;
    logic       bit_tick = 1'b0;
    logic       txd, busy, buf_empty;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    ser_tx_dbuf i_ser_tx_dbuf (
        .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(wr_en), .wr_data(wr_data),
        .mode(mode), .dbuf_en(dbuf_en), .msb_first(msb_first), .two_stop(two_stop),
        .bit_tick(bit_tick), .txd(txd), .busy(busy), .buf_empty(buf_empty)
    );

    // Vector: {mode[1:0], msb_first, two_stop, frame_len[3:0], data[7:0]}
    localparam logic [15:0] VECS [8] = '{
        16'h4AA5, 16'h6A3C, 16'h5B81, 16'h7BFF,
        16'h08B2, 16'h28B2, 16'hB84E, 16'hC801
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input logic [1:0] m, input logic msb,
                                     input logic [7:0] d, input int idx);
        if (m == 2'b01) begin
            if (idx == 0) return 1'b0;
            if (idx <= 8) return d[idx-1];
            return 1'b1;
        end
        return msb ? d[7-idx] : d[idx];
    endfunction

    task automatic tick_once();
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_frame(input string req, input logic [7:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            chk(req, {31'd0, txd}, {31'd0, exp_bit(mode, msb_first, d, i)});
            chk(req, {31'd0, busy}, 32'd1);
            tick_once();
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 txd", {31'd0, txd}, 32'd1);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 buf_empty", {31'd0, buf_empty}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5: table walk
        for (int v = 0; v < 8; v++) begin
            mode      = VECS[v][15:14];
            msb_first = VECS[v][13];
            two_stop  = VECS[v][12];
            dbuf_en   = 1'b1;
            write_byte(VECS[v][7:0]);
            // R6: direct load from idle
            chk("R6 buf_empty", {31'd0, buf_empty}, 32'd1);
            run_frame("R2 R3 R4 frame bit", VECS[v][7:0], int'(VECS[v][11:8]));
            chk("R3 R5 busy at end", {31'd0, busy}, 32'd0);
            chk("R2 idle txd", {31'd0, txd}, 32'd1);
            chk("R10 idle empty", {31'd0, buf_empty}, 32'd1);
        end

        // R7 R8: back-to-back in character mode
        mode = 2'b01; msb_first = 1'b0; two_stop = 1'b0; dbuf_en = 1'b1;
        write_byte(8'h55);
        write_byte(8'hC3);
        chk("R7 queued", {31'd0, buf_empty}, 32'd0);
        run_frame("R8 first frame", 8'h55, 10);
        chk("R8 busy kept", {31'd0, busy}, 32'd1);
        chk("R8 empty again", {31'd0, buf_empty}, 32'd1);
        run_frame("R8 second frame", 8'hC3, 10);
        chk("R8 idle after", {31'd0, busy}, 32'd0);

        // R7: later write replaces held byte
        mode = 2'b00; msb_first = 1'b1;
        write_byte(8'h11);
        write_byte(8'h22);
        write_byte(8'h33);
        run_frame("R7 current frame", 8'h11, 8);
        run_frame("R7 replaced byte", 8'h33, 8);
        chk("R7 idle after", {31'd0, busy}, 32'd0);

        // R9: buffering off drops write during frame
        mode = 2'b00; msb_first = 1'b0; dbuf_en = 1'b0;
        write_byte(8'h6A);
        write_byte(8'h95);
        chk("R9 still empty", {31'd0, buf_empty}, 32'd1);
        run_frame("R9 frame", 8'h6A, 8);
        chk("R9 no second frame", {31'd0, busy}, 32'd0);
        tick_once();
        chk("R9 stays idle", {31'd0, busy}, 32'd0);

        // R7: auxiliary mode forces buffering
        mode = 2'b10; msb_first = 1'b0; dbuf_en = 1'b0;
        write_byte(8'h0F);
        write_byte(8'hF0);
        chk("R7 aux queued", {31'd0, buf_empty}, 32'd0);
        run_frame("R7 aux first", 8'h0F, 8);
        run_frame("R7 aux second", 8'hF0, 8);
        chk("R7 aux idle", {31'd0, busy}, 32'd0);

        // R5: no tick, no movement
        mode = 2'b01; dbuf_en = 1'b1; two_stop = 1'b1;
        write_byte(8'h80);
        repeat (6) @(negedge clk);
        chk("R5 start held", {31'd0, txd}, 32'd0);
        chk("R5 busy held", {31'd0, busy}, 32'd1);
        run_frame("R5 frame", 8'h80, 11);
        chk("R5 idle", {31'd0, busy}, 32'd0);

        // R1: synchronous clear mid-frame with held byte
        two_stop = 1'b0;
        write_byte(8'hAA);
        write_byte(8'hBB);
        repeat (3) tick_once();
        srst = 1'b1;
        @(negedge clk);
        srst = 1'b0;
        chk("R1 clear busy", {31'd0, busy}, 32'd0);
        chk("R1 clear txd", {31'd0, txd}, 32'd1);
        chk("R1 clear empty", {31'd0, buf_empty}, 32'd1);
        repeat (3) tick_once();
        chk("R1 held byte dropped", {31'd0, busy}, 32'd0);

        finish_run();
    end

endmodule